// File: doc/BRIEF.md
# Serial Register Access Port

A slave serial port that lets an external controller read and write an 8-bit register file. The controller pulls chip select low and sends a 16-bit instruction on the first sixteen serial clock rising edges. The instruction gives the direction, the number of data bytes and the starting register address. The data bytes follow. Written bytes appear as single-cycle write strobes toward the register file. Read bytes are fetched with single-cycle read strobes and shifted out on falling serial clock edges.

All pins are oversampled in the system clock domain through two-stage synchronizers, so the serial clock must stay well below a quarter of the system clock. Short transfers of one, two or three bytes may be paused with chip select high on any byte boundary. A streaming transfer runs until chip select rises, and the address steps after every byte. The port watches writes to register address 0 and takes two configuration bits from them: 3-wire versus 4-wire operation, and the bit order.

Top module: `spi_regport`

## Requirements
- R1: The instruction word is 16 bits: bit 15 selects read (1) or write (0), bits 14:13 give the length (00 = 1 byte, 01 = 2, 10 = 3, 11 = streaming), and bits 12:0 give the start address. In the default bit order, each byte of the instruction and of the data is sent most significant bit first, high instruction byte first.
- R2: Write data is sampled on serial clock rising edges. Each completed data byte produces one reg_we_o pulse carrying that byte and its address. After the number of bytes set by the length field, further serial clock edges produce no strobe.
- R3: For a read, reg_re_o pulses with the byte's address before that byte's first bit is shifted out. reg_rdata_i is taken one cycle after the pulse. The bits appear on the output after serial clock falling edges, ready for the controller to sample on the next rising edge.
- R4: In streaming mode the byte count is unlimited. In the default bit order, the address increments by one after each byte without skipping any address. The transfer ends when chip select rises on a byte boundary.
- R5: A write to address 0 with bit 6 set selects LSB-first order for every later instruction and data byte, with the low instruction byte sent first. In this order the address decrements after each byte.
- R6: In 1-, 2- and 3-byte modes, chip select high on a byte boundary before the last byte stalls the transfer. This holds in both the instruction and the data part. The transfer continues when chip select falls again.
- R7: Chip select rising on a non-byte boundary aborts the transfer. The partial byte is discarded with no strobe, bytes already completed stay written, and the next transfer is decoded from a fresh instruction.
- R8: After reset, read data is driven on sdo_o (4-wire). A write to address 0 with bit 7 set selects 3-wire operation: read data is then driven on sdio_o, sdio_oe_o is high only during the data part of a read, and sdo_oe_o stays low. sdo_oe_o and sdio_oe_o are never high together.
- R9: Two cycles after chip select is seen high, both sdo_oe_o and sdio_oe_o are low.
- R10: reg_we_o and reg_re_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_ni | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in (controller to port) |
| sdio_o | output | 1 | Serial read data in 3-wire operation |
| sdio_oe_o | output | 1 | Output enable for sdio_o |
| sdo_o | output | 1 | Serial read data in 4-wire operation |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| reg_addr_o | output | 13 | Register address for the current strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_we_o |
| reg_we_o | output | 1 | Write strobe, one cycle per completed byte |
| reg_re_o | output | 1 | Read fetch strobe |
| reg_rdata_i | input | 8 | Read data, valid the cycle after reg_re_o |

## Verification
The assertions check the strobe discipline on every cycle: single-cycle write and read pulses that never overlap. They also check that the two output enables never overlap and that both fall once chip select has been high long enough to pass the synchronizers. The byte-level behaviour can only be shown by the bench's scenarios. That covers instruction decoding, byte counts, address stepping in both bit orders, stall against abort at chip-select rise, discarding of partial bytes, and the switch between the two read-data pins. The bench compares the register file contents and the read-back bytes with its own model.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  localparam logic [1:0] LEN_STREAM = 2'b11;
  localparam int unsigned CFG_TW_BIT  = 7;
  localparam int unsigned CFG_LSB_BIT = 6;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              cs_act_i,
  input  logic              cs_rise_i,
  input  logic              din_i,
  output logic              three_wire_o,
  output logic              lsb_first_o,
  output logic              rd_phase_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  localparam int unsigned INSTR_W = ADDR_W + 3;
  localparam int unsigned ICNT_W  = $clog2(INSTR_W);
  localparam int unsigned BIT_W   = $clog2(DATA_W);

  phase_e              phase_q;
  logic [ICNT_W-1:0]   icnt_q;
  logic [BIT_W-1:0]    bcnt_q;
  logic [INSTR_W-1:0]  isr_q, isr_nxt;
  logic [DATA_W-1:0]   rsr_q, rsr_nxt;
  logic                rd_q, stream_q;
  logic [1:0]          rem_q;
  logic [ADDR_W-1:0]   cur_addr_q, step_addr;
  logic                boundary, finish, last_byte;

  assign isr_nxt   = lsb_first_o ? {din_i, isr_q[INSTR_W-1:1]} : {isr_q[INSTR_W-2:0], din_i};
  assign rsr_nxt   = lsb_first_o ? {din_i, rsr_q[DATA_W-1:1]}  : {rsr_q[DATA_W-2:0], din_i};
  assign step_addr = lsb_first_o ? cur_addr_q - ADDR_W'(1) : cur_addr_q + ADDR_W'(1);
  assign boundary  = (phase_q == PH_INSTR) ? (icnt_q[BIT_W-1:0] == '0) : (bcnt_q == '0);
  // end of cycle: off-boundary abort, short transfer done, or streaming stop
  assign finish    = !boundary || (phase_q == PH_DONE) || (phase_q == PH_DATA && stream_q);
  assign last_byte = !stream_q && (rem_q == 2'd0);
  assign rd_phase_o = (phase_q == PH_DATA) && rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_INSTR;
      icnt_q       <= '0;
      bcnt_q       <= '0;
      isr_q        <= '0;
      rsr_q        <= '0;
      rd_q         <= 1'b0;
      stream_q     <= 1'b0;
      rem_q        <= '0;
      cur_addr_q   <= '0;
      three_wire_o <= 1'b0;
      lsb_first_o  <= 1'b0;
      reg_addr_o   <= '0;
      reg_wdata_o  <= '0;
      reg_we_o     <= 1'b0;
      reg_re_o     <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (cs_rise_i) begin
        if (finish) begin
          phase_q <= PH_INSTR;
          icnt_q  <= '0;
          bcnt_q  <= '0;
        end
      end else if (rise_i && cs_act_i) begin
        unique case (phase_q)
          PH_INSTR: begin
            isr_q <= isr_nxt;
            if (icnt_q == ICNT_W'(INSTR_W-1)) begin
              icnt_q     <= '0;
              bcnt_q     <= '0;
              phase_q    <= PH_DATA;
              rd_q       <= isr_nxt[INSTR_W-1];
              rem_q      <= isr_nxt[INSTR_W-2 -: 2];
              stream_q   <= (isr_nxt[INSTR_W-2 -: 2] == LEN_STREAM);
              cur_addr_q <= isr_nxt[ADDR_W-1:0];
              if (isr_nxt[INSTR_W-1]) begin
                reg_re_o   <= 1'b1;
                reg_addr_o <= isr_nxt[ADDR_W-1:0];
              end
            end else begin
              icnt_q <= icnt_q + ICNT_W'(1);
            end
          end
          PH_DATA: begin
            rsr_q <= rsr_nxt;
            if (bcnt_q == BIT_W'(DATA_W-1)) begin
              bcnt_q     <= '0;
              cur_addr_q <= step_addr;
              if (last_byte) phase_q <= PH_DONE;
              else if (!stream_q) rem_q <= rem_q - 2'd1;
              if (!rd_q) begin
                reg_we_o    <= 1'b1;
                reg_addr_o  <= cur_addr_q;
                reg_wdata_o <= rsr_nxt;
                if (cur_addr_q == '0) begin
                  three_wire_o <= rsr_nxt[CFG_TW_BIT];
                  lsb_first_o  <= rsr_nxt[CFG_LSB_BIT];
                end
              end else if (!last_byte) begin
                reg_re_o   <= 1'b1;
                reg_addr_o <= step_addr;
              end
            end else begin
              bcnt_q <= bcnt_q + BIT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              fall_i,
  input  logic              lsb_first_i,
  output logic              bit_o
);
  logic              load_q;
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      sr_q   <= '0;
      bit_o  <= 1'b0;
    end else begin
      load_q <= fetch_i;
      if (load_q) begin
        sr_q <= rdata_i;
      end else if (fall_i) begin
        bit_o <= lsb_first_i ? sr_q[0] : sr_q[DATA_W-1];
        sr_q  <= lsb_first_i ? {1'b0, sr_q[DATA_W-1:1]} : {sr_q[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic       sclk_s, cs_s, din_s;
  logic       sclk_q, cs_q;
  logic       rise, fall, cs_act, cs_rise;
  logic       three_wire, lsb_first, rd_phase, tx_bit;

  // pin order: {sclk, cs_n, sdio}; idle values after reset
  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, sdio_i}),
    .q_o    (pins_s)
  );
  assign {sclk_s, cs_s, din_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign cs_act  = ~cs_s;
  assign cs_rise = cs_s & ~cs_q;

  spi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .cs_act_i     (cs_act),
    .cs_rise_i    (cs_rise),
    .din_i        (din_s),
    .three_wire_o (three_wire),
    .lsb_first_o  (lsb_first),
    .rd_phase_o   (rd_phase),
    .reg_addr_o   (reg_addr_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_we_o     (reg_we_o),
    .reg_re_o     (reg_re_o)
  );

  spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (reg_re_o),
    .rdata_i     (reg_rdata_i),
    .fall_i      (fall),
    .lsb_first_i (lsb_first),
    .bit_o       (tx_bit)
  );

  assign sdo_o     = tx_bit;
  assign sdio_o    = tx_bit;
  assign sdo_oe_o  = cs_act & ~three_wire;
  assign sdio_oe_o = cs_act & three_wire & rd_phase;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic sdo_oe_o,
  input logic sdio_oe_o
);
  // R10
  we_re_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  // R10
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R10
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R8
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdo_oe_o && sdio_oe_o));

  // R9
  hiz_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> (!sdo_oe_o && !sdio_oe_o));
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .sdo_oe_o  (sdo_oe_o),
  .sdio_oe_o (sdio_oe_o)
);

// File: tb/tb_spi_regport.sv
module tb_spi_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdio_m = 1'b0;
  logic        sdio_o, sdio_oe, sdo, sdo_oe;
  logic [12:0] addr;
  logic [7:0]  wdata, rdata;
  logic        we, re;

  always #10 clk = ~clk;

  spi_regport dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdio_m),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
    .reg_rdata_i(rdata)
  );

  // register file responder
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int we_cnt = 0;
  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (we) begin mem[addr[5:0]] <= wdata; we_cnt <= we_cnt + 1; end
    if (re) rdata <= mem[addr[5:0]];
  end

  int n_chk = 0, n_bad = 0;
  logic tw_mode = 1'b0, lsb_mode = 1'b0;
  logic in_write = 1'b0, in_rdata = 1'b0, oe_all = 1'b1;
  int bad_oe = 0;
  logic done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always @(negedge clk) begin
    if (rst_n && ((sdo_oe && tw_mode) || (sdio_oe && in_write))) bad_oe <= bad_oe + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sclk_bit(input logic b, output logic r);
    sdio_m = b;
    repeat (8) @(negedge clk);
    r = tw_mode ? sdio_o : sdo;
    if (in_rdata) oe_all = oe_all & (tw_mode ? sdio_oe : sdo_oe);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    logic rb;
    r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int k = lsb_mode ? i : 7 - i;
      sclk_bit(b[k], rb);
      r[k] = rb;
    end
  endtask

  task automatic send_bits(input int n);
    logic rb;
    for (int i = 0; i < n; i++) sclk_bit(1'b1, rb);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_instr_byte(input logic rd, input logic [1:0] len, input logic [12:0] a,
                                 input int idx);
    logic [15:0] w;
    logic [7:0] d;
    w = {rd, len, a};
    // MSB-first: high byte first; LSB-first: low byte first
    if ((idx == 0) ^ lsb_mode) send_byte(w[15:8], d);
    else send_byte(w[7:0], d);
  endtask

  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] a, input int n);
    logic [7:0] d;
    in_write = !rd;
    cs_low();
    send_instr_byte(rd, len, a, 0);
    send_instr_byte(rd, len, a, 1);
    in_rdata = rd;
    oe_all = 1'b1;
    for (int j = 0; j < n; j++) begin
      send_byte(wbuf[j], d);
      rbuf[j] = d;
    end
    in_rdata = 1'b0;
    cs_high();
    in_write = 1'b0;
  endtask

  task automatic model_write(input logic [12:0] a, input int n);
    logic [5:0] p;
    p = a[5:0];
    for (int j = 0; j < n; j++) begin
      exp_mem[p] = wbuf[j];
      p = lsb_mode ? p - 6'd1 : p + 6'd1;
    end
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < 64; i++) chk(req, {24'h0, mem[i]}, {24'h0, exp_mem[i]});
  endtask

  task automatic cmp_read(input string req, input logic [12:0] a, input int n);
    logic [5:0] p;
    p = a[5:0];
    for (int j = 0; j < n; j++) begin
      chk(req, {24'h0, rbuf[j]}, {24'h0, exp_mem[p]});
      p = lsb_mode ? p - 6'd1 : p + 6'd1;
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    wbuf[0] = v;
    xfer(1'b0, 2'b00, 13'd0, 1);
    model_write(13'd0, 1);
  endtask

  initial begin
    int base;
    logic [7:0] d;
    void'($urandom(32'd7741));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state R9 R10
    chk("R9 reset sdo_oe", {31'h0, sdo_oe}, 0);
    chk("R9 reset sdio_oe", {31'h0, sdio_oe}, 0);
    chk("R10 reset strobes", {30'h0, we, re}, 0);

    // R1 R2: single-byte write, extra clocks after the byte ignored
    base = we_cnt;
    wbuf[0] = 8'h5A;
    in_write = 1'b1;
    cs_low();
    send_instr_byte(1'b0, 2'b00, 13'd5, 0);
    send_instr_byte(1'b0, 2'b00, 13'd5, 1);
    send_byte(wbuf[0], d);
    send_bits(8);
    cs_high();
    in_write = 1'b0;
    model_write(13'd5, 1);
    chk("R2 one-byte strobe count", we_cnt - base, 1);
    chk("R1 one-byte data at 5", {24'h0, mem[5]}, 32'h5A);

    // R2: three-byte write
    base = we_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(1'b0, 2'b10, 13'd10, 3);
    model_write(13'd10, 3);
    chk("R2 three-byte strobe count", we_cnt - base, 3);
    cmp_mem("R2 three-byte write");

    // R3 R8: two-byte read on sdo in 4-wire
    base = we_cnt;
    xfer(1'b1, 2'b01, 13'd10, 2);
    cmp_read("R3 two-byte read", 13'd10, 2);
    chk("R8 sdo_oe during read", {31'h0, oe_all}, 1);
    chk("R3 read makes no write", we_cnt - base, 0);

    // R4: streaming write then read
    base = we_cnt;
    for (int j = 0; j < 6; j++) wbuf[j] = 8'hA0 + 8'(j);
    xfer(1'b0, 2'b11, 13'd20, 6);
    model_write(13'd20, 6);
    chk("R4 stream strobe count", we_cnt - base, 6);
    cmp_mem("R4 stream write");
    xfer(1'b1, 2'b11, 13'd20, 5);
    cmp_read("R4 stream read", 13'd20, 5);

    // R6: stalls inside instruction and between data bytes
    base = we_cnt;
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    in_write = 1'b1;
    cs_low();
    send_instr_byte(1'b0, 2'b10, 13'd30, 0);
    cs_high();
    chk("R9 stall sdo_oe low", {31'h0, sdo_oe}, 0);
    cs_low();
    send_instr_byte(1'b0, 2'b10, 13'd30, 1);
    send_byte(wbuf[0], d);
    cs_high();
    chk("R6 stall after byte 0 count", we_cnt - base, 1);
    cs_low();
    send_byte(wbuf[1], d);
    cs_high();
    cs_low();
    send_byte(wbuf[2], d);
    cs_high();
    in_write = 1'b0;
    model_write(13'd30, 3);
    chk("R6 stalled write count", we_cnt - base, 3);
    cmp_mem("R6 stalled write");

    // R7: abort mid-byte
    base = we_cnt;
    wbuf[0] = 8'hA5;
    in_write = 1'b1;
    cs_low();
    send_instr_byte(1'b0, 2'b01, 13'd40, 0);
    send_instr_byte(1'b0, 2'b01, 13'd40, 1);
    send_byte(wbuf[0], d);
    send_bits(3);
    cs_high();
    in_write = 1'b0;
    model_write(13'd40, 1);
    chk("R7 abort strobe count", we_cnt - base, 1);
    cmp_mem("R7 abort keeps partial out");
    wbuf[0] = 8'h3C;
    xfer(1'b0, 2'b00, 13'd41, 1);
    model_write(13'd41, 1);
    chk("R7 fresh instruction after abort", {24'h0, mem[41]}, 32'h3C);

    // random mix, MSB-first 4-wire
    for (int t = 0; t < 14; t++) begin
      logic rd;
      logic [1:0] len;
      logic [12:0] a;
      int n;
      rd  = 1'($urandom % 2);
      len = 2'($urandom % 4);
      a   = 13'(1 + $urandom % 40);
      n   = (len == 2'b11) ? 4 + int'($urandom % 4) : int'(len) + 1;
      for (int j = 0; j < 8; j++) wbuf[j] = 8'($urandom);
      base = we_cnt;
      xfer(rd, len, a, n);
      if (rd) begin
        cmp_read("R3 random read", a, n);
        chk("R3 random read no write", we_cnt - base, 0);
      end else begin
        model_write(a, n);
        chk("R2 random write count", we_cnt - base, n);
      end
    end
    cmp_mem("R4 random write contents");

    // R8: switch to 3-wire
    cfg_write(8'h80);
    tw_mode = 1'b1;
    xfer(1'b1, 2'b10, 13'd10, 3);
    cmp_read("R8 3-wire read on sdio", 13'd10, 3);
    chk("R8 sdio_oe during read", {31'h0, oe_all}, 1);
    wbuf[0] = 8'h77;
    xfer(1'b0, 2'b00, 13'd12, 1);
    model_write(13'd12, 1);
    cmp_mem("R8 3-wire write");

    // R5: LSB-first, 3-wire kept
    cfg_write(8'hC0);
    lsb_mode = 1'b1;
    base = we_cnt;
    wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'h6E;
    xfer(1'b0, 2'b11, 13'd50, 3);
    model_write(13'd50, 3);
    chk("R5 lsb stream count", we_cnt - base, 3);
    chk("R5 lsb addr 49", {24'h0, mem[49]}, 32'h80);
    cmp_mem("R5 lsb decrementing write");
    xfer(1'b1, 2'b11, 13'd50, 3);
    cmp_read("R5 lsb decrementing read", 13'd50, 3);

    // back to MSB-first 4-wire, written in LSB-first order
    tw_mode = 1'b0;
    cfg_write(8'h00);
    lsb_mode = 1'b0;
    xfer(1'b1, 2'b00, 13'd11, 1);
    cmp_read("R8 4-wire restored", 13'd11, 1);

    chk("R8 no output enable on wrong pin", bad_oe, 0);
    chk("R9 idle sdo_oe", {31'h0, sdo_oe}, 0);
    chk("R9 idle sdio_oe", {31'h0, sdio_oe}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule